// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Device Model

This block is a synthesizable, clocked behavioural model of a byte-wide one-time-programmable memory. It lets the logic that drives such a memory, whether a programmer sequencer or a read path, be checked against a digital stand-in for the real part. The analog conditions of the real part appear as plain flags: `vpp_high` for programming voltage on the shared output-enable pin, `id_hv` for the identification voltage on an address line, and `vcc_prog` for the raised supply used while programming. Every input is sampled on the rising edge of `clk`.

On each clock the model decodes an operating mode from chip enable, output enable and the flags. It then drives either a stored byte or one of two identification bytes, or leaves the bus undriven. A program pulse is chip enable held low with `vpp_high` set. It commits on the cycle chip enable returns high, and it can only clear bits. The same kind of pulse with the margin address pattern sets or clears a margin latch instead. A status flag marks input combinations that a well-behaved programmer never produces. A test-only `erase_all` input returns every bit to 1, and a test-only `weak_en` input makes every cell need extra pulses before it takes a program.

Top module: `otp_eprom_model`

## Requirements
- R1: During and after reset, `dq_oe` is 0, `dq_out` is 0, `margin_on` is 0 and every byte holds 0xFF. A cycle with `erase_all` high sets every byte back to 0xFF from the next cycle on, and `margin_on` keeps its value.
- R2: When a cycle has `ce_n`=0, `oe_n`=0, `vpp_high`=0 and `id_hv`=0, then after that clock edge `dq_oe` is 1 and `dq_out` is the byte at array index `addr` modulo DEPTH. Address bits above the index are ignored, so 0x0112 reads the same byte as 0x0012.
- R3: When a cycle has `ce_n`=1, `oe_n`=1 or `vpp_high`=1, then after that edge `dq_oe` is 0 and `dq_out` is 0. With `ce_n`=1 this holds whatever `oe_n` and `vpp_high` are.
- R4: A valid program pulse writes. Such a pulse is at least MIN_PULSE consecutive cycles with `ce_n`=0 and `vpp_high`=1, followed by a cycle with `ce_n`=1, `vpp_high`=1, `vcc_prog`=1 and `id_hv`=0. On the edge of that last cycle, the byte at `addr` becomes its old value AND `dq_in`, both sampled in that cycle. No bit ever goes from 0 to 1 except by erase or reset.
- R5: A program pulse with fewer than MIN_PULSE low cycles, a pulse during which `vpp_high` drops, or a pulse that ends with `vcc_prog`=0 leaves the array unchanged.
- R6: When a cycle has `ce_n`=0, `oe_n`=0, `vpp_high`=0 and `id_hv`=1, then after that edge `dq_oe` is 1 and `dq_out` is 0x20 if `addr` bit 0 is 0, or 0x3D if it is 1.
- R7: A pulse shaped like R4 that ends with `id_hv`=1 and `addr` bit 8 = 1 writes nothing to the array. On its final edge it loads `addr` bit 10 into `margin_on`, where 1 sets the latch and 0 clears it. `margin_on` changes at no other time.
- R8: The model counts valid program pulses that have not yet written. The count restarts on a pulse to a different array index and clears when a pulse writes. With `weak_en`=1, a pulse writes only if this count is already WEAK_EXTRA for the same index. With `weak_en`=0, every valid pulse writes.
- R9: `illegal` is 1 after an edge exactly when that cycle had any of three cases: `vpp_high`=1 and `id_hv`=1 with `addr` bit 8 = 0; `vpp_high`=1 and `vcc_prog`=0; or `ce_n`=0, `vpp_high`=0 and `id_hv`=1 with any `addr` bit above bit 0 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Simulation clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| erase_all | input | 1 | Test-only erase: every bit to 1 |
| weak_en | input | 1 | Test-only flag: cells need WEAK_EXTRA extra pulses |
| addr | input | ADDR_W | Byte address |
| ce_n | input | 1 | Chip enable, active low; program pulse strobe |
| oe_n | input | 1 | Output enable, active low |
| vpp_high | input | 1 | Programming voltage present on the output-enable pin |
| id_hv | input | 1 | Identification voltage present on address bit 9 |
| vcc_prog | input | 1 | Supply raised to the programming level |
| dq_in | input | DATA_W | Data presented on the bus for programming |
| dq_out | output | DATA_W | Data driven on the bus (0 while not driving) |
| dq_oe | output | 1 | Bus drive enable; 0 means high impedance |
| margin_on | output | 1 | Margin latch state |
| illegal | output | 1 | Forbidden input combination seen in the previous cycle |

## Verification
Bus outputs and `illegal` are registered, so each is due one edge after the cycle that caused it. The bench samples them on the falling edge that follows, with inputs changed only on falling edges. A write or margin change lands on the edge of the cycle in which `ce_n` returns high. A read issued in the next cycle shows the new byte one edge later, and the directed reads wait for exactly that. A behavioural reference updated on every rising edge gives the expected bus, margin and status values, and the bench compares them at every falling edge, including a long stretch of pseudo-random pin activity.

// File: rtl/otp_model_pkg.sv
package otp_model_pkg;

  typedef enum logic [2:0] {
    M_STANDBY,
    M_OUT_OFF,
    M_READ,
    M_SIG_READ,
    M_PROGRAM,
    M_PROG_HOLD,
    M_MARGIN
  } otp_mode_e;

  localparam logic [7:0] SIG_BYTE_LO = 8'h20;
  localparam logic [7:0] SIG_BYTE_HI = 8'h3D;

  localparam int MARGIN_SEL_BIT = 8;
  localparam int MARGIN_VAL_BIT = 10;

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
  import otp_model_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_high,
  input  logic              id_hv,
  input  logic              vcc_prog,
  input  logic [ADDR_W-1:0] addr,
  output otp_mode_e         mode,
  output logic              drive,
  output logic              sig_sel,
  output logic              illegal_now
);

  logic hi_addr_set;

  assign hi_addr_set = |addr[ADDR_W-1:1];

  always_comb begin
    if (ce_n) begin
      mode = vpp_high ? M_PROG_HOLD : M_STANDBY;
    end else if (vpp_high) begin
      mode = (id_hv && addr[MARGIN_SEL_BIT]) ? M_MARGIN : M_PROGRAM;
    end else if (oe_n) begin
      mode = M_OUT_OFF;
    end else begin
      mode = id_hv ? M_SIG_READ : M_READ;
    end
  end

  assign drive   = (mode == M_READ) || (mode == M_SIG_READ);
  assign sig_sel = (mode == M_SIG_READ);

  always_comb begin
    illegal_now = 1'b0;
    if (vpp_high && id_hv && !addr[MARGIN_SEL_BIT]) illegal_now = 1'b1;
    if (vpp_high && !vcc_prog)                      illegal_now = 1'b1;
    if (!ce_n && !vpp_high && id_hv && hi_addr_set) illegal_now = 1'b1;
  end

endmodule

// File: rtl/otp_pulse_timer.sv
module otp_pulse_timer #(
  parameter int MIN_PULSE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic vpp_high,
  output logic pulse_done
);

  localparam int CNT_W = $clog2(MIN_PULSE + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_PULSE);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (ce_n || !vpp_high) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (cnt_q != CNT_MAX) begin
      cnt_d  = cnt_q + CNT_W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign pulse_done = ce_n && vpp_high && (cnt_q == CNT_MAX);

  AST_PULSE_FOLLOWS_LOW: assert property (@(posedge clk) disable iff (!rst_n) pulse_done |-> ($past(!ce_n) && $past(vpp_high))); // R5

endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl #(
  parameter int IDX_W      = 8,
  parameter int WEAK_EXTRA = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_done,
  input  logic             id_hv,
  input  logic             sel_bit,
  input  logic             val_bit,
  input  logic             vcc_prog,
  input  logic             weak_en,
  input  logic [IDX_W-1:0] idx,
  output logic             wr_en,
  output logic             margin_on
);

  localparam int HIT_W = $clog2(WEAK_EXTRA + 2);
  localparam logic [HIT_W-1:0] HIT_NEED = HIT_W'(WEAK_EXTRA);

  logic             prog_end, marg_end;
  logic [HIT_W-1:0] hits_q, hits_d, eff_hits;
  logic [IDX_W-1:0] last_q;
  logic             margin_q;

  assign prog_end = pulse_done && !id_hv && vcc_prog;
  assign marg_end = pulse_done && id_hv && sel_bit;

  assign eff_hits = (last_q == idx) ? hits_q : '0;
  assign wr_en    = prog_end && (!weak_en || (eff_hits >= HIT_NEED));

  always_comb begin
    hits_d = hits_q;
    if (prog_end) begin
      hits_d = wr_en ? '0 : (eff_hits + HIT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hits_q <= '0;
      last_q <= '0;
    end else if (prog_end) begin
      hits_q <= hits_d;
      last_q <= idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      margin_q <= 1'b0;
    end else if (marg_end) begin
      margin_q <= val_bit;
    end
  end

  assign margin_on = margin_q;

  AST_WEAK_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n) (prog_end && weak_en && (last_q != idx) && (WEAK_EXTRA > 0)) |-> !wr_en); // R8

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_all,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] words [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic [DATA_W-1:0] word_q, word_d;
    logic              word_en;

    assign word_en = erase_all || (wr_en && (wr_idx == IDX_W'(w)));

    always_comb begin
      word_d = word_q & wr_data;
      if (erase_all) word_d = '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '1;
      end else if (word_en) begin
        word_q <= word_d;
      end
    end

    assign words[w] = word_q;

    AST_BITS_ONLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) !$past(erase_all) |-> ((word_q & ~$past(word_q)) == '0)); // R4
  end

  assign rd_data = words[rd_idx];

endmodule

// File: rtl/otp_out_stage.sv
module otp_out_stage
  import otp_model_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drive,
  input  logic              sig_sel,
  input  logic              sig_bit,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              illegal_now,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              illegal
);

  logic [DATA_W-1:0] out_d, out_q;
  logic              oe_q, ill_q;

  always_comb begin
    out_d = '0;
    if (drive) begin
      if (sig_sel) out_d = DATA_W'(sig_bit ? SIG_BYTE_HI : SIG_BYTE_LO);
      else         out_d = rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      oe_q  <= 1'b0;
      ill_q <= 1'b0;
    end else begin
      out_q <= out_d;
      oe_q  <= drive;
      ill_q <= illegal_now;
    end
  end

  assign dq_out  = out_q;
  assign dq_oe   = oe_q;
  assign illegal = ill_q;

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !dq_oe |-> (dq_out == '0)); // R3
  AST_SIG_CODE: assert property (@(posedge clk) disable iff (!rst_n) (dq_oe && $past(sig_sel)) |-> ((dq_out == DATA_W'(SIG_BYTE_LO)) || (dq_out == DATA_W'(SIG_BYTE_HI)))); // R6

endmodule

// File: rtl/otp_eprom_model.sv
module otp_eprom_model
  import otp_model_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 256,
  parameter int MIN_PULSE  = 3,
  parameter int WEAK_EXTRA = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_all,
  input  logic              weak_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_high,
  input  logic              id_hv,
  input  logic              vcc_prog,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              margin_on,
  output logic              illegal
);

  localparam int IDX_W = $clog2(DEPTH);

  otp_mode_e         mode;
  logic              drive, sig_sel, illegal_now;
  logic              pulse_done, wr_en;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] rd_data;

  assign idx = addr[IDX_W-1:0];

  otp_mode_decode #(.ADDR_W(ADDR_W)) u_decode (
    .ce_n        (ce_n),
    .oe_n        (oe_n),
    .vpp_high    (vpp_high),
    .id_hv       (id_hv),
    .vcc_prog    (vcc_prog),
    .addr        (addr),
    .mode        (mode),
    .drive       (drive),
    .sig_sel     (sig_sel),
    .illegal_now (illegal_now)
  );

  otp_pulse_timer #(.MIN_PULSE(MIN_PULSE)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .vpp_high   (vpp_high),
    .pulse_done (pulse_done)
  );

  otp_prog_ctrl #(.IDX_W(IDX_W), .WEAK_EXTRA(WEAK_EXTRA)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .pulse_done (pulse_done),
    .id_hv      (id_hv),
    .sel_bit    (addr[MARGIN_SEL_BIT]),
    .val_bit    (addr[MARGIN_VAL_BIT]),
    .vcc_prog   (vcc_prog),
    .weak_en    (weak_en),
    .idx        (idx),
    .wr_en      (wr_en),
    .margin_on  (margin_on)
  );

  otp_cell_array #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .erase_all (erase_all),
    .wr_en     (wr_en),
    .wr_idx    (idx),
    .wr_data   (dq_in),
    .rd_idx    (idx),
    .rd_data   (rd_data)
  );

  otp_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .drive       (drive),
    .sig_sel     (sig_sel),
    .sig_bit     (addr[0]),
    .rd_data     (rd_data),
    .illegal_now (illegal_now),
    .dq_out      (dq_out),
    .dq_oe       (dq_oe),
    .illegal     (illegal)
  );

  AST_MARGIN_ONLY_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(margin_on) |-> $past(pulse_done && id_hv && addr[MARGIN_SEL_BIT])); // R7
  AST_ILLEGAL_NEEDS_HV: assert property (@(posedge clk) disable iff (!rst_n) illegal |-> ($past(vpp_high) || $past(id_hv))); // R9
  AST_DRIVE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n) dq_oe |-> ($past(!ce_n) && $past(!oe_n) && $past(!vpp_high))); // R3

endmodule

// File: tb/otp_eprom_model_tb_top.sv
module otp_eprom_model_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 8;
  localparam int DEPTH      = 256;
  localparam int MINP       = 3;
  localparam int WEAK       = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              erase_all = 1'b0;
  logic              weak_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              ce_n = 1'b1;
  logic              oe_n = 1'b1;
  logic              vpp_high = 1'b0;
  logic              id_hv = 1'b0;
  logic              vcc_prog = 1'b0;
  logic [DATA_W-1:0] dq_in = '0;
  logic [DATA_W-1:0] dq_out;
  logic              dq_oe, margin_on, illegal;

  int n_chk  = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_eprom_model #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
    .MIN_PULSE(MINP), .WEAK_EXTRA(WEAK)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .erase_all(erase_all), .weak_en(weak_en),
    .addr(addr), .ce_n(ce_n), .oe_n(oe_n), .vpp_high(vpp_high),
    .id_hv(id_hv), .vcc_prog(vcc_prog), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .margin_on(margin_on), .illegal(illegal)
  );

  // behavioural reference
  logic [7:0] mem_m [DEPTH];
  int         cnt_m, hits_m, last_m, m_idx, m_eff;
  logic       margin_m, m_done, m_drive;
  logic [7:0] exp_out;
  logic       exp_oe, exp_ill;
  string      exp_tag;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'hFF;
      cnt_m = 0; hits_m = 0; last_m = 0; margin_m = 1'b0;
      exp_out = 8'h00; exp_oe = 1'b0; exp_ill = 1'b0; exp_tag = "R1";
    end else begin
      m_idx   = int'(addr) % DEPTH;
      m_drive = !ce_n && !oe_n && !vpp_high;
      exp_oe  = m_drive;
      if (!m_drive) begin
        exp_out = 8'h00; exp_tag = "R3";
      end else if (id_hv) begin
        exp_out = addr[0] ? 8'h3D : 8'h20; exp_tag = "R6";
      end else begin
        exp_out = mem_m[m_idx]; exp_tag = "R2";
      end
      exp_ill = (vpp_high && id_hv && !addr[8]) || (vpp_high && !vcc_prog) ||
                (!ce_n && !vpp_high && id_hv && (addr[15:1] != 15'd0));
      m_done = ce_n && vpp_high && (cnt_m == MINP);
      if (ce_n || !vpp_high) cnt_m = 0;
      else if (cnt_m < MINP) cnt_m = cnt_m + 1;
      if (m_done && !id_hv && vcc_prog) begin
        m_eff = (last_m == m_idx) ? hits_m : 0;
        if (!weak_en || m_eff >= WEAK) begin
          mem_m[m_idx] = mem_m[m_idx] & dq_in;
          hits_m = 0;
        end else begin
          hits_m = m_eff + 1;
        end
        last_m = m_idx;
      end
      if (m_done && id_hv && addr[8]) margin_m = addr[10];
      if (erase_all) for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'hFF;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // cycle-by-cycle compare, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk(exp_tag, "dq_oe", int'(dq_oe), int'(exp_oe));
      chk(exp_tag, "dq_out", int'(dq_out), int'(exp_out));
      chk("R7", "margin_on", int'(margin_on), int'(margin_m));
      chk("R9", "illegal", int'(illegal), int'(exp_ill));
    end
  end

  task automatic quiet();
    ce_n = 1'b1; oe_n = 1'b1; vpp_high = 1'b0; id_hv = 1'b0; vcc_prog = 1'b0;
    erase_all = 1'b0;
  endtask

  task automatic read_at(logic [15:0] a, logic sig, logic [7:0] exp, string tag);
    ce_n = 1'b0; oe_n = 1'b0; vpp_high = 1'b0; id_hv = sig; addr = a;
    @(negedge clk);
    chk(tag, "read oe", int'(dq_oe), 1);
    chk(tag, "read data", int'(dq_out), int'(exp));
    quiet();
    @(negedge clk);
  endtask

  task automatic prog(logic [15:0] a, logic [7:0] d, int low_cyc, logic vccp);
    oe_n = 1'b1; id_hv = 1'b0; vcc_prog = vccp; vpp_high = 1'b1; addr = a; dq_in = d;
    @(negedge clk);
    ce_n = 1'b0;
    repeat (low_cyc) @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk);
    quiet();
    @(negedge clk);
  endtask

  task automatic margin_pulse(logic setv);
    oe_n = 1'b1; id_hv = 1'b1; vcc_prog = 1'b1; vpp_high = 1'b1; dq_in = 8'h00;
    addr = 16'h0100 | (setv ? 16'h0400 : 16'h0000);
    @(negedge clk);
    ce_n = 1'b0;
    repeat (MINP) @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk);
    quiet();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    quiet();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1", "oe after reset", int'(dq_oe), 0);
    chk("R1", "margin after reset", int'(margin_on), 0);
    read_at(16'h0000, 1'b0, 8'hFF, "R1");
    read_at(16'h00FF, 1'b0, 8'hFF, "R1");

    // R4: program clears bits only
    prog(16'h0012, 8'hA5, MINP, 1'b1);
    read_at(16'h0012, 1'b0, 8'hA5, "R4");
    prog(16'h0012, 8'h3C, MINP + 2, 1'b1);
    read_at(16'h0012, 1'b0, 8'h24, "R4");

    // R2: upper address bits alias
    read_at(16'h0112, 1'b0, 8'h24, "R2");
    read_at(16'h0013, 1'b0, 8'hFF, "R2");

    // R5: rejected pulses
    prog(16'h0020, 8'h00, MINP - 1, 1'b1);
    read_at(16'h0020, 1'b0, 8'hFF, "R5");
    prog(16'h0021, 8'h00, MINP, 1'b0);
    read_at(16'h0021, 1'b0, 8'hFF, "R5");
    vcc_prog = 1'b1; vpp_high = 1'b1; oe_n = 1'b1; addr = 16'h0022; dq_in = 8'h00;
    @(negedge clk);
    ce_n = 1'b0; repeat (2) @(negedge clk);
    vpp_high = 1'b0; @(negedge clk);
    vpp_high = 1'b1; @(negedge clk);
    ce_n = 1'b1; @(negedge clk);
    quiet(); @(negedge clk);
    read_at(16'h0022, 1'b0, 8'hFF, "R5");

    // R3: standby and output disable
    ce_n = 1'b1; oe_n = 1'b0; vpp_high = 1'b0; addr = 16'h0012;
    @(negedge clk);
    chk("R3", "standby oe", int'(dq_oe), 0);
    vpp_high = 1'b1; vcc_prog = 1'b1;
    @(negedge clk);
    chk("R3", "standby with vpp oe", int'(dq_oe), 0);
    quiet(); ce_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    chk("R3", "output disable oe", int'(dq_oe), 0);
    chk("R3", "output disable data", int'(dq_out), 0);
    quiet(); @(negedge clk);

    // R6: identification bytes
    read_at(16'h0000, 1'b1, 8'h20, "R6");
    read_at(16'h0001, 1'b1, 8'h3D, "R6");

    // R7: margin latch
    margin_pulse(1'b1);
    chk("R7", "margin set", int'(margin_on), 1);
    read_at(16'h0000, 1'b0, 8'hFF, "R7");
    margin_pulse(1'b0);
    chk("R7", "margin clear", int'(margin_on), 0);

    // R8: weak cells
    weak_en = 1'b1;
    prog(16'h0030, 8'h00, MINP, 1'b1);
    read_at(16'h0030, 1'b0, 8'hFF, "R8");
    prog(16'h0030, 8'h00, MINP, 1'b1);
    read_at(16'h0030, 1'b0, 8'hFF, "R8");
    prog(16'h0030, 8'h00, MINP, 1'b1);
    read_at(16'h0030, 1'b0, 8'h00, "R8");
    prog(16'h0031, 8'h0F, MINP, 1'b1);
    prog(16'h0032, 8'h0F, MINP, 1'b1);
    prog(16'h0031, 8'h0F, MINP, 1'b1);
    read_at(16'h0031, 1'b0, 8'hFF, "R8");
    weak_en = 1'b0;

    // R9: illegal combinations
    id_hv = 1'b1; vpp_high = 1'b1; vcc_prog = 1'b1; addr = 16'h0000;
    @(negedge clk);
    chk("R9", "id+vpp no margin pattern", int'(illegal), 1);
    quiet(); vpp_high = 1'b1; vcc_prog = 1'b0;
    @(negedge clk);
    chk("R9", "vpp without prog supply", int'(illegal), 1);
    quiet(); ce_n = 1'b0; oe_n = 1'b0; id_hv = 1'b1; addr = 16'h0004;
    @(negedge clk);
    chk("R9", "id read with address bits set", int'(illegal), 1);
    quiet(); @(negedge clk);
    chk("R9", "clean cycle", int'(illegal), 0);

    // R1: erase
    erase_all = 1'b1; @(negedge clk);
    erase_all = 1'b0;
    read_at(16'h0012, 1'b0, 8'hFF, "R1");
    read_at(16'h0030, 1'b0, 8'hFF, "R1");

    // mixed pin activity, checked by the per-cycle reference
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ce_n     = lfsr[0] & lfsr[1];
      oe_n     = lfsr[2] & lfsr[3];
      vpp_high = lfsr[4] | lfsr[5];
      id_hv    = lfsr[6] & lfsr[7] & lfsr[11];
      vcc_prog = lfsr[8] | lfsr[9];
      weak_en  = lfsr[12] & lfsr[13] & lfsr[14];
      addr     = {5'b0, lfsr[10], 1'b0, lfsr[15], 2'b00, lfsr[5:0]};
      dq_in    = lfsr[15:8];
      if (lfsr[3:0] == 4'h0) ce_n = 1'b0;
      @(negedge clk);
      if (lfsr[1:0] != 2'b00) begin
        @(negedge clk);
      end
    end
    quiet(); weak_en = 1'b0;
    repeat (3) @(negedge clk);

    finish_run();
  end

endmodule